// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block sits between the two open-drain lines of an I2C bus and the slave logic that decodes bytes. Both lines are sampled by a system clock that runs many times faster than SCL. After a synchronizer, the block compares each new sample with the one before it. From that comparison it reports four events as one-cycle pulses: the first START of a transfer, a repeated START, a STOP, and each SCL rising edge, which is the moment a data bit is valid. It also holds a level that shows whether the bus is currently owned by a master.

The slave logic uses the SCL rising-edge pulse to shift in data bits. It uses the START pulses to reset its byte counter. It uses the STOP pulse to drop any transfer in progress. The block treats every SDA change while SCL is high as a bus condition, never as data.

A STOP is not legal in the same SCL high phase as the START before it. The block masks STOP detection from a START until the next SCL falling edge. A STOP at any other point ends the transfer, even when it comes partway through a byte.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset, bus_busy_o is 0 and start_o, rstart_o, stop_o and scl_rise_o are all 0.
- R2: A 1-to-0 change of SDA while SCL is high, with the bus free, gives exactly one start_o pulse and sets bus_busy_o to 1.
- R3: A 1-to-0 change of SDA while SCL is high, with bus_busy_o already 1, gives one rstart_o pulse and no start_o or stop_o pulse, and bus_busy_o stays 1.
- R4: A 0-to-1 change of SDA while SCL is high gives one stop_o pulse and clears bus_busy_o, provided at least one SCL falling edge has occurred since the last START.
- R5: A 0-to-1 change of SDA in the same SCL high phase as a START gives no stop_o pulse, and bus_busy_o stays 1.
- R6: A STOP that arrives partway through a byte, after some data bits, is accepted: one stop_o pulse, and bus_busy_o returns to 0.
- R7: Each SCL 0-to-1 change gives exactly one scl_rise_o pulse.
- R8: SDA changes while SCL is low produce no start_o, rstart_o or stop_o pulse.
- R9: Each event output is high for one system clock cycle at a time, and at most one of start_o, rstart_o and stop_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_i | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw SCL line, asynchronous to clk_i |
| sda_i | input | 1 | Raw SDA line, asynchronous to clk_i |
| start_o | output | 1 | Pulse: START seen while the bus was free |
| rstart_o | output | 1 | Pulse: START seen while the bus was busy |
| stop_o | output | 1 | Pulse: accepted STOP |
| scl_rise_o | output | 1 | Pulse: SCL rising edge, data bit valid |
| bus_busy_o | output | 1 | Level: bus is owned by a master |

## Verification
The STOP detector and the START mask can act in the same SCL high phase. The bench provokes this by pulling SDA low and then releasing it while SCL stays high. It judges the result by checking that stop_o stays silent and bus_busy_o stays 1. It then checks that a later START in that transfer counts as a repeated START, and that a STOP after a full SCL pulse still frees the bus.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    // Number of flops in the synchronizer. One more delay stage follows them.
    localparam int SYNC_STAGES = 2;
    // The two bus lines
    localparam int N_LINES     = 2;
    localparam int IDX_SCL     = 0;
    localparam int IDX_SDA     = 1;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_lines_t;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
        logic scl_rise;
    } bus_events_t;

    // SDA falls while SCL is high in both samples
    function automatic logic is_start(bus_lines_t prv, bus_lines_t cur);
        return prv.scl & cur.scl & prv.sda & ~cur.sda;
    endfunction

    // SDA rises while SCL is high in both samples
    function automatic logic is_stop(bus_lines_t prv, bus_lines_t cur);
        return prv.scl & cur.scl & ~prv.sda & cur.sda;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prv_o
);

    localparam int LAST = STAGES;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        // STAGES synchronizer flops, then one delay flop
        logic [LAST:0] shift_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shift_q <= '1;  // lines idle high
            end else begin
                shift_q <= {shift_q[LAST-1:0], raw_i[g]};
            end
        end

        assign cur_o[g] = shift_q[LAST-1];
        assign prv_o[g] = shift_q[LAST];
    end

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  bus_lines_t  cur_i,
    input  bus_lines_t  prv_i,
    output bus_events_t evt_o,
    output logic        busy_o
);

    logic        start_det;
    logic        stop_raw;
    logic        scl_fall;
    logic        scl_rise;
    logic        mask_q;
    logic        busy_q;
    bus_events_t evt_q;

    assign start_det = is_start(prv_i, cur_i);
    assign stop_raw  = is_stop(prv_i, cur_i);
    assign scl_rise  = cur_i.scl & ~prv_i.scl;
    assign scl_fall  = ~cur_i.scl & prv_i.scl;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            evt_q  <= '0;
            busy_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            evt_q          <= '0;
            evt_q.scl_rise <= scl_rise;
            if (start_det) begin
                // START has priority over any SDA rise in the same cycle
                evt_q.start  <= ~busy_q;
                evt_q.rstart <= busy_q;
                busy_q       <= 1'b1;
                mask_q       <= 1'b1;
            end else if (stop_raw && !mask_q) begin
                evt_q.stop <= 1'b1;
                busy_q     <= 1'b0;
            end
            if (scl_fall) begin
                mask_q <= 1'b0;
            end
        end
    end

    assign evt_o  = evt_q;
    assign busy_o = busy_q;

    AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_q.start |-> busy_q && !$past(busy_q));  // R2
    AST_RSTART_KEEPS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_q.rstart |-> busy_q && $past(busy_q));  // R3
    AST_STOP_FREES: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_q.stop |-> !busy_q);  // R4
    AST_MASKED_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_q && stop_raw) |=> !evt_q.stop);  // R5
    AST_LOW_SCL_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cur_i.scl) |=> !(evt_q.start || evt_q.rstart || evt_q.stop));  // R8
    AST_ONE_CONDITION: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({evt_q.start, evt_q.rstart, evt_q.stop}));  // R9
    AST_START_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_q.start |=> !evt_q.start);  // R9
    AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_q.scl_rise |=> !evt_q.scl_rise);  // R7

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic rstart_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic bus_busy_o
);

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] cur_lines;
    logic [N_LINES-1:0] prv_lines;
    bus_lines_t         cur_s;
    bus_lines_t         prv_s;
    bus_events_t        evt;

    assign raw_lines[IDX_SCL] = scl_i;
    assign raw_lines[IDX_SDA] = sda_i;

    i2c_line_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .raw_i (raw_lines),
        .cur_o (cur_lines),
        .prv_o (prv_lines)
    );

    assign cur_s.scl = cur_lines[IDX_SCL];
    assign cur_s.sda = cur_lines[IDX_SDA];
    assign prv_s.scl = prv_lines[IDX_SCL];
    assign prv_s.sda = prv_lines[IDX_SDA];

    i2c_cond_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cur_i  (cur_s),
        .prv_i  (prv_s),
        .evt_o  (evt),
        .busy_o (bus_busy_o)
    );

    assign start_o    = evt.start;
    assign rstart_o   = evt.rstart;
    assign stop_o     = evt.stop;
    assign scl_rise_o = evt.scl_rise;

    AST_RESET_FREE: assert property (@(posedge clk_i)
        $past(rst_i) |-> !bus_busy_o && !start_o && !stop_o);  // R1

endmodule

// File: tb/i2c_cond_detect_tb_top.sv
module i2c_cond_detect_tb_top;

    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic start_o, rstart_o, stop_o, scl_rise_o, bus_busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int c_start = 0, c_rstart = 0, c_stop = 0, c_rise = 0, c_overlap = 0;
    logic p_start = 0, p_rstart = 0, p_stop = 0, p_rise = 0;

    always #2.5 clk = ~clk;

    i2c_cond_detect dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .scl_i      (scl),
        .sda_i      (sda),
        .start_o    (start_o),
        .rstart_o   (rstart_o),
        .stop_o     (stop_o),
        .scl_rise_o (scl_rise_o),
        .bus_busy_o (bus_busy_o)
    );

    // Pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (start_o)    c_start++;
            if (rstart_o)   c_rstart++;
            if (stop_o)     c_stop++;
            if (scl_rise_o) c_rise++;
            if ((start_o && p_start) || (rstart_o && p_rstart) || (stop_o && p_stop) ||
                (scl_rise_o && p_rise) || (int'(start_o) + int'(rstart_o) + int'(stop_o) > 1))
                c_overlap++;
        end
        p_start = start_o; p_rstart = rstart_o; p_stop = stop_o; p_rise = scl_rise_o;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lines(logic c, logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        hold(HOLD);
    endtask

    task automatic clear_counts();
        c_start = 0; c_rstart = 0; c_stop = 0; c_rise = 0;
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(bus_busy_o), 0);
        chk("R1 start after reset", int'(start_o), 0);
        chk("R1 stop after reset", int'(stop_o), 0);
        chk("R1 rise after reset", int'(scl_rise_o), 0);
    endtask

    task automatic t_start_stop();
        clear_counts();
        set_lines(1, 0);                 // START
        chk("R2 start count", c_start, 1);
        chk("R2 busy set", int'(bus_busy_o), 1);
        set_lines(0, 0);
        set_lines(1, 0);
        set_lines(1, 1);                 // STOP after a full SCL pulse
        chk("R4 stop count", c_stop, 1);
        chk("R4 busy cleared", int'(bus_busy_o), 0);
        chk("R7 one rise", c_rise, 1);
    endtask

    task automatic t_data_bits();
        clear_counts();
        set_lines(1, 0);                 // START
        set_lines(0, 0);
        for (int i = 0; i < 5; i++) begin
            set_lines(0, logic'(i % 2)); // data change while SCL low
            set_lines(0, logic'((i + 1) % 2));
            set_lines(1, logic'((i + 1) % 2));
            set_lines(0, logic'((i + 1) % 2));
        end
        chk("R7 rise per bit", c_rise, 5);
        chk("R8 no stop from low-SCL SDA edges", c_stop, 0);
        chk("R8 no extra start", c_start + c_rstart, 1);
        set_lines(0, 0);
        set_lines(1, 0);
        set_lines(1, 1);
        chk("R4 stop after bits", c_stop, 1);
    endtask

    task automatic t_rstart();
        clear_counts();
        set_lines(1, 0);
        set_lines(0, 0);
        set_lines(0, 1);
        set_lines(1, 1);
        set_lines(1, 0);                 // START while busy
        chk("R3 rstart count", c_rstart, 1);
        chk("R3 single start", c_start, 1);
        chk("R3 no stop", c_stop, 0);
        chk("R3 busy held", int'(bus_busy_o), 1);
        set_lines(0, 0);
        set_lines(1, 0);
        set_lines(1, 1);
        chk("R4 stop after rstart", c_stop, 1);
    endtask

    task automatic t_masked();
        clear_counts();
        set_lines(1, 0);                 // START
        set_lines(1, 1);                 // STOP in same high phase
        chk("R5 masked stop", c_stop, 0);
        chk("R5 busy held", int'(bus_busy_o), 1);
        set_lines(0, 1);
        set_lines(1, 1);
        set_lines(1, 0);                 // counts as repeated START
        chk("R5 later start is rstart", c_rstart, 1);
        set_lines(0, 0);
        set_lines(1, 0);
        set_lines(1, 1);
        chk("R5 stop accepted afterwards", c_stop, 1);
        chk("R5 busy cleared afterwards", int'(bus_busy_o), 0);
    endtask

    task automatic t_early_stop();
        clear_counts();
        set_lines(1, 0);
        set_lines(0, 0);
        set_lines(0, 1);
        set_lines(1, 1);
        set_lines(0, 1);
        set_lines(0, 0);
        set_lines(1, 0);                 // two bits taken
        set_lines(1, 1);                 // STOP mid-byte
        chk("R6 early stop count", c_stop, 1);
        chk("R6 busy cleared", int'(bus_busy_o), 0);
        chk("R6 bits before stop", c_rise, 2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        hold(4);
        rst = 1'b0;
        hold(1);
        t_reset();
        hold(HOLD);
        t_start_stop();
        t_data_bits();
        t_rstart();
        t_masked();
        t_early_stop();
        hold(HOLD);
        chk("R9 single-cycle exclusive pulses", c_overlap, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule